// File: doc/BRIEF.md
# Alternating-Polarity Ripple Adder

This block adds two unsigned operands of a parameterised, even width plus a carry in, and presents the sum and carry out from a register one clock after the operands are applied. The carry chain is a plain ripple through one full-adder cell per bit. Each cell is built from two half adders, and the carry out is formed from the two half-adder carries.

Adjacent cells are two different circuits. An even-indexed cell takes a true carry and drives the complement of its carry out through a NOR gate. The odd-indexed cell above it accepts that complemented carry directly. It forms its sum from the exclusive-NOR of its operand bits and the inverted carry, and it drives a true carry to the next pair. No inverter sits anywhere on the carry path. The width must be even, because the chain is a cascade of identical even/odd pairs.

Carry in enters bit 0 in true polarity. The carry out leaves the last (odd) cell in true polarity. A synchronous active-high reset clears the output register.

Top module: `paired_ripple_adder`

## Requirements
- R1: One rising clock edge after operands `opA`, `opB` and `carryIn` are sampled with `rst` low, `sum` equals (`opA` + `opB` + `carryIn`) modulo 2^WIDTH.
- R2: On the same cycle, `carryOut` equals bit WIDTH of `opA` + `opB` + `carryIn`, in true polarity (1 means overflow).
- R3: `carryIn` enters bit 0 in true polarity: zero operands with `carryIn` = 1 give `sum` = 1 and `carryOut` = 0.
- R4: A rising edge with `rst` high clears `sum` to zero and `carryOut` to 0, whatever the operands; the outputs stay cleared while `rst` is held.
- R5: Every bit pair adds its two operand bits with the incoming carry exactly as a 2-bit adder would, across the inverted link inside the pair. All-ones operands with `carryIn` = 1 ripple a carry through every pair and give `sum` = all ones and `carryOut` = 1.
- R6: The outputs change only at a rising clock edge. Operand changes between edges do not reach `sum` or `carryOut` before the next edge.
- R7: WIDTH must be even. The adder is correct at WIDTH = 8 and at WIDTH = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0, true polarity |
| sum | output | WIDTH | Registered sum |
| carryOut | output | 1 | Registered carry out, true polarity |

## Verification
Two functions can coincide in one cycle: a register clear and an operand set that would produce a nonzero sum with carry. The bench provokes this by holding all-ones operands with carry in set while `rst` is high, and expects zero outputs. It also changes the operands during held reset and expects the outputs to stay zero. A second collision is a long carry ripple meeting the capture edge. All-ones plus carry in, and the near-exhaustive 8-bit sweep, are judged against sums the bench computes itself, sampled one edge after the inputs are applied.

// File: rtl/pra_pkg.sv
package pra_pkg;
  // strobes from the control module to the datapath register
  typedef struct packed {
    logic clr;   // clear sum and carry at this edge
    logic load;  // capture the adder result at this edge
  } regStrobe_t;
endpackage

// File: rtl/pra_cell_even.sv
// Even-indexed bit: true carry in, complemented carry out.
module pra_cell_even (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic coutN
);
  logic halfSum, halfCarry, secondCarry;
  // first half adder
  assign halfSum   = a ^ b;
  assign halfCarry = a & b;
  // second half adder
  assign s           = halfSum ^ cin;
  assign secondCarry = halfSum & cin;
  // carries merged by a NOR: the carry leaves inverted
  assign coutN = ~(halfCarry | secondCarry);
endmodule

// File: rtl/pra_cell_odd.sv
// Odd-indexed bit: complemented carry in, true carry out.
module pra_cell_odd (
  input  logic a,
  input  logic b,
  input  logic cinN,
  output logic s,
  output logic cout
);
  logic halfEq, halfCarry, propAndCarry;
  // first half adder, equality form
  assign halfEq    = ~(a ^ b);
  assign halfCarry = a & b;
  // sum from the XNOR and the inverted incoming carry
  assign s = halfEq ^ cinN;
  // propagate AND carry, taken straight from the inverted signals
  assign propAndCarry = ~(halfEq | cinN);
  assign cout = halfCarry | propAndCarry;
endmodule

// File: rtl/pra_pair.sv
// One even/odd pair; the link between the two cells is inverted.
module pra_pair (
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       cin,
  output logic [1:0] s,
  output logic       cout
);
  logic linkN;

  pra_cell_even evenCell (
    .a(a[0]), .b(b[0]), .cin(cin), .s(s[0]), .coutN(linkN)
  );

  pra_cell_odd oddCell (
    .a(a[1]), .b(b[1]), .cinN(linkN), .s(s[1]), .cout(cout)
  );

  // R5: the pair behaves as a 2-bit adder with carry
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_pair_arith_R5: assert ({cout, s} == 3'({1'b0, a}) + 3'({1'b0, b}) + 3'(cin))
        else $error("pair arithmetic mismatch");
    end
  end
endmodule

// File: rtl/pra_ctrl.sv
// Turns the reset input into register strobes for the datapath.
module pra_ctrl
  import pra_pkg::*;
(
  input  logic       rst,
  output regStrobe_t ctl
);
  always_comb begin
    ctl.clr  = rst;
    ctl.load = ~rst;
  end
endmodule

// File: rtl/pra_datapath.sv
// Pairwise carry cascade plus the output register.
module pra_datapath
  import pra_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  regStrobe_t       ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumQ,
  output logic             carryQ
);
  localparam int PAIRS = WIDTH / 2;
  localparam int W1    = WIDTH + 1;

  generate
    if (WIDTH % 2 != 0 || WIDTH < 2) begin : g_badWidth
      $error("WIDTH must be even and at least 2");
    end
  endgenerate

  logic [PAIRS:0]   chainCarry;  // true-polarity carries between pairs
  logic [WIDTH-1:0] rawSum;

  assign chainCarry[0] = carryIn;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    pra_pair pairInst (
      .a   (opA[2*p+1 : 2*p]),
      .b   (opB[2*p+1 : 2*p]),
      .cin (chainCarry[p]),
      .s   (rawSum[2*p+1 : 2*p]),
      .cout(chainCarry[p+1])
    );
  end

  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      sumQ   <= '0;
      carryQ <= 1'b0;
    end else if (ctl.load) begin
      sumQ   <= rawSum;
      carryQ <= chainCarry[PAIRS];
    end
  end

  // behavioural reference, used only by the checks below
  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + W1'(carryIn);

  assert_sum_R1: assert property (@(posedge clk) disable iff (ctl.clr)
    $past(ctl.load) |-> sumQ == $past(refTotal[WIDTH-1:0]))
    else $error("registered sum mismatch");

  assert_carry_R2: assert property (@(posedge clk) disable iff (ctl.clr)
    $past(ctl.load) |-> carryQ == $past(refTotal[WIDTH]))
    else $error("registered carry mismatch");

  assert_reset_clear_R4: assert property (@(posedge clk)
    ctl.clr |=> (sumQ == '0 && carryQ == 1'b0))
    else $error("reset did not clear outputs");
endmodule

// File: rtl/paired_ripple_adder.sv
module paired_ripple_adder
  import pra_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  regStrobe_t ctl;

  pra_ctrl ctrlInst (
    .rst(rst),
    .ctl(ctl)
  );

  pra_datapath #(.WIDTH(WIDTH)) dpInst (
    .clk    (clk),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .carryIn(carryIn),
    .sumQ   (sum),
    .carryQ (carryOut)
  );
endmodule

// File: tb/paired_ripple_adder_test.sv
`timescale 1ns/1ps
module paired_ripple_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;

  int checks = 0;
  int fails  = 0;

  paired_ripple_adder #(.WIDTH(8)) uut (
    .clk(clk), .rst(rst), .opA(a8), .opB(b8), .carryIn(c8),
    .sum(s8), .carryOut(co8)
  );

  paired_ripple_adder #(.WIDTH(16)) uut16 (
    .clk(clk), .rst(rst), .opA(a16), .opB(b16), .carryIn(c16),
    .sum(s16), .carryOut(co16)
  );

  task automatic expect9(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect17(string tag, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // apply at a falling edge, sample at the next falling edge
  task automatic run8(string tag, logic [7:0] a, logic [7:0] b, logic c);
    @(negedge clk);
    a8 = a; b8 = b; c8 = c;
    @(negedge clk);
    expect9(tag, {co8, s8}, 9'(a) + 9'(b) + 9'(c));
  endtask

  task automatic run16(string tag, logic [15:0] a, logic [15:0] b, logic c);
    @(negedge clk);
    a16 = a; b16 = b; c16 = c;
    @(negedge clk);
    expect17(tag, {co16, s16}, 17'(a) + 17'(b) + 17'(c));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R4: reset state, with busy operands present
    a8 = 8'hFF; b8 = 8'hFF; c8 = 1'b1;
    a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1;
    repeat (3) @(negedge clk);
    expect9("R4 reset clears 8-bit", {co8, s8}, 9'h000);
    expect17("R4 reset clears 16-bit", {co16, s16}, 17'h00000);
    a8 = 8'h5A; b8 = 8'hC3;
    @(negedge clk);
    expect9("R4 held reset ignores operands", {co8, s8}, 9'h000);
    rst = 1'b0;

    // R3: carry in enters bit 0 in true polarity
    run8("R3 carry in 8-bit", 8'h00, 8'h00, 1'b1);
    run16("R3 carry in 16-bit", 16'h0000, 16'h0000, 1'b1);
    run8("R1 zero operands", 8'h00, 8'h00, 1'b0);

    // R5: full ripple through every pair
    run8("R5 all ones plus carry 8-bit", 8'hFF, 8'hFF, 1'b1);
    run8("R5 all ones plus one 8-bit", 8'hFF, 8'h00, 1'b1);
    run16("R5 all ones plus carry 16-bit", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R5 all ones plus one 16-bit", 16'hFFFF, 16'h0000, 1'b1);
    run8("R2 alternating bits", 8'hAA, 8'h55, 1'b1);

    // R6: operand change between edges does not reach outputs
    run8("R6 setup", 8'h12, 8'h34, 1'b0);
    a8 = 8'hF0; b8 = 8'hF0; c8 = 1'b1;
    #4;
    expect9("R6 outputs hold before edge", {co8, s8}, 9'h046);
    @(negedge clk);
    expect9("R6 outputs update after edge", {co8, s8}, 9'h1E1);

    // R1 R2: near-exhaustive 8-bit sweep
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j += 7) begin
        run8("R1 R2 sweep 8-bit", 8'(i), 8'(j), 1'b0);
        run8("R1 R2 sweep 8-bit cin", 8'(i), 8'(255 - j), 1'b1);
      end
    end

    // R7: random 16-bit operands
    for (int k = 0; k < 3000; k++) begin
      run16("R7 random 16-bit", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    // R4: reset during operation, colliding with a carrying sum
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'hFF; c8 = 1'b1; rst = 1'b1;
    @(negedge clk);
    expect9("R4 reset wins over carrying sum", {co8, s8}, 9'h000);
    rst = 1'b0;
    @(negedge clk);
    expect9("R1 result resumes after reset", {co8, s8}, 9'h1FF);

    finishRun();
  end
endmodule